// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block carries out the bus side of accepting a maskable external interrupt. Once the core hands it a request, it runs two acknowledge machine cycles one after the other. Each machine cycle steps through the bus states T1, T2, T3 and T4. Wait states can be added after T3 for as long as the bus ready input stays low. During the first cycle the block only announces the acknowledge. In the second cycle the external interrupt controller places its type byte on the data bus, and the block latches that byte.

For the whole sequence the block does three things. It turns off the core's address/data drivers so the bus floats. It holds a lock output high, which keeps the arbiter from granting the bus to another master. It drives the active-low acknowledge command from T2 through T4 of each cycle, and the command stays low through any wait states. At least one clock with the command released separates the two cycles. When the sequence finishes, the block presents the captured byte together with that byte shifted left by two. The shifted value is the byte offset into the interrupt vector table.

The request side is a valid/ready handshake. `req_ready` is high only while no sequence is running. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_valid` has no effect while `req_ready` is low. The result side is a one-clock strobe with no back-pressure, so the consumer must take it in that clock.

Top module: `irq_ack_sequencer`

## Requirements
- R1: While reset is held, and after it until a request is taken: `inta_n`=1, `hold_lock`=0, `bus_oe`=1, `type_valid`=0 and `req_ready`=1.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the clock after acceptance until the clock of `type_valid`. `req_valid` raised while `req_ready` is 0 starts nothing.
- R3: Number the clocks after acceptance 1, 2, 3 and so on. With ready high throughout, `inta_n` is 1 in clock 1 (T1) and 0 in clocks 2 to 4. It is 1 in clocks 5 and 6 (gap, T1). It is 0 in clocks 7 to 9. That makes exactly two low pulses of three clocks each.
- R4: `bus_rdy` is sampled at the edge ending T3 and at the edge ending each wait state. Every sample that reads 0 adds one clock, with `inta_n` still 0, before T4.
- R5: Between the two acknowledge pulses, `inta_n` stays 1 for GAP_CYCLES idle clocks plus the T1 of the second cycle (two clocks by default).
- R6: `bus_oe` is 0 from clock 1 of the sequence through the T4 of the second cycle.
- R7: `hold_lock` is 1 from clock 1 of the sequence through the T4 of the second cycle. It falls in the clock where `type_valid` is 1.
- R8: `type_data` takes the value of `bus_din` at the edge that ends T4 of the second cycle, and only at that edge. Bus values during the first cycle, during wait states, or at any other time are not captured.
- R9: `type_valid` is 1 for exactly one clock. That clock is the one right after the second acknowledge pulse ends.
- R10: `vec_ptr` equals `type_data` multiplied by 4 (`type_data` shifted left by two, low bits zero). With `type_data`=8'hFF it is 10'h3FC.
- R11: A request presented in the clock where `type_valid` is 1 is accepted at once. The next clock is T1 of a new sequence, and `hold_lock` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request to run an acknowledge sequence |
| req_ready | output | 1 | High when a request can be taken |
| bus_rdy | input | 1 | Bus ready; low adds wait states after T3 |
| bus_din | input | DATA_W | Data bus input |
| inta_n | output | 1 | Acknowledge command, active low |
| bus_oe | output | 1 | Address/data driver enable; 0 while the bus floats |
| hold_lock | output | 1 | Blocks hold grants while high |
| type_valid | output | 1 | One-clock strobe for a captured type byte |
| type_data | output | DATA_W | Captured type byte |
| vec_ptr | output | DATA_W+2 | Vector table byte offset (type times 4) |

## Verification
Two functions can coincide in one clock. The completion strobe of one sequence can land in the same clock as the acceptance of the next request, because `req_ready` returns high in the very clock that `type_valid` pulses. The bench provokes this by raising `req_valid` exactly in the strobe clock of a first sequence. It then checks three things: the strobe still carries the first byte, the following clock is already T1 of a new sequence with the lock high, and the second sequence captures its own byte. It also raises `req_valid` during the gap of a running sequence and checks that this request is dropped, with the bus staying idle afterwards.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

  // Bus state of one machine cycle
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_T3,
    PH_TW,
    PH_T4
  } tphase_e;

  // Position inside the two-cycle acknowledge sequence
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FIRST,
    SQ_GAP,
    SQ_SECOND
  } seq_e;

endpackage

// File: rtl/ack_tstate.sv
module ack_tstate
  import irq_ack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bus_rdy,
  output logic cmd_on,
  output logic last_t
);

  tphase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start) ph_d = PH_T1;
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = PH_T3;
      PH_T3,
      PH_TW:   ph_d = bus_rdy ? PH_T4 : PH_TW;
      PH_T4:   ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  // Command is active from T2 up to and including T4, waits included
  assign cmd_on = (ph_q == PH_T2) || (ph_q == PH_T3) ||
                  (ph_q == PH_TW) || (ph_q == PH_T4);
  assign last_t = (ph_q == PH_T4);

endmodule

// File: rtl/ack_ctrl.sv
module ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic last_t,
  output logic start,
  output logic capture,
  output logic busy
);

  localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  seq_e          st_q;
  logic [GW-1:0] gap_q;
  logic          gap_done;

  assign gap_done = (st_q == SQ_GAP) && (gap_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      gap_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE:   if (req_fire) st_q <= SQ_FIRST;
        SQ_FIRST:  if (last_t) begin
                     st_q  <= SQ_GAP;
                     gap_q <= GW'(GAP_CYCLES - 1);
                   end
        SQ_GAP:    if (gap_done) st_q <= SQ_SECOND;
                   else          gap_q <= gap_q - 1'b1;
        SQ_SECOND: if (last_t) st_q <= SQ_IDLE;
        default:   st_q <= SQ_IDLE;
      endcase
    end
  end

  assign start   = ((st_q == SQ_IDLE) && req_fire) || gap_done;
  assign capture = (st_q == SQ_SECOND) && last_t;
  assign busy    = (st_q != SQ_IDLE);

endmodule

// File: rtl/ack_capture.sv
module ack_capture #(
  parameter int DATA_W    = 8,
  parameter int PTR_SHIFT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          capture,
  input  logic [DATA_W-1:0]             bus_in,
  output logic [DATA_W-1:0]             type_q,
  output logic                          valid_q,
  output logic [DATA_W+PTR_SHIFT-1:0]   ptr
);

  localparam int PTR_W = DATA_W + PTR_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
      if (capture) type_q <= bus_in;
    end
  end

  assign ptr = PTR_W'(type_q) << PTR_SHIFT;

endmodule

// File: rtl/irq_ack_sequencer.sv
module irq_ack_sequencer #(
  parameter int DATA_W     = 8,
  parameter int PTR_SHIFT  = 2,
  parameter int GAP_CYCLES = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        bus_rdy,
  input  logic [DATA_W-1:0]           bus_din,
  output logic                        inta_n,
  output logic                        bus_oe,
  output logic                        hold_lock,
  output logic                        type_valid,
  output logic [DATA_W-1:0]           type_data,
  output logic [DATA_W+PTR_SHIFT-1:0] vec_ptr
);

  logic busy, start, capture, cmd_on, last_t, req_fire;

  assign req_fire = req_valid && !busy;

  ack_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .last_t(last_t),
    .start(start), .capture(capture), .busy(busy)
  );

  ack_tstate u_tst (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_rdy(bus_rdy),
    .cmd_on(cmd_on), .last_t(last_t)
  );

  ack_capture #(.DATA_W(DATA_W), .PTR_SHIFT(PTR_SHIFT)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .bus_in(bus_din),
    .type_q(type_data), .valid_q(type_valid), .ptr(vec_ptr)
  );

  assign req_ready = !busy;
  assign hold_lock = busy;
  assign bus_oe    = !busy;
  assign inta_n    = !cmd_on;

endmodule

// File: rtl/irq_ack_checker.sv
module irq_ack_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              inta_n,
  input logic              bus_oe,
  input logic              hold_lock,
  input logic              type_valid,
  input logic [DATA_W-1:0] type_data
);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (hold_lock && inta_n));

  p_lock_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> hold_lock);

  p_lock_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_lock) |-> type_valid);

  p_bus_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> !bus_oe);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    type_valid |=> !type_valid);

  p_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    type_valid |-> ($past(!inta_n) && inta_n));

  p_type_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(type_data) |-> type_valid);

endmodule

bind irq_ack_sequencer irq_ack_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .inta_n(inta_n), .bus_oe(bus_oe), .hold_lock(hold_lock),
  .type_valid(type_valid), .type_data(type_data)
);

// File: tb/irq_ack_sequencer_tb.sv
module irq_ack_sequencer_tb;

  localparam int CLK_NS = 10;
  localparam int DW     = 8;
  localparam int SH     = 2;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          bus_rdy = 1'b1;
  logic [DW-1:0] bus_din = '0;
  logic          req_ready, inta_n, bus_oe, hold_lock, type_valid;
  logic [DW-1:0] type_data;
  logic [DW+SH-1:0] vec_ptr;

  irq_ack_sequencer #(.DATA_W(DW), .PTR_SHIFT(SH), .GAP_CYCLES(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .bus_rdy(bus_rdy), .bus_din(bus_din), .inta_n(inta_n), .bus_oe(bus_oe),
    .hold_lock(hold_lock), .type_valid(type_valid), .type_data(type_data),
    .vec_ptr(vec_ptr)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // One sequence: a and b are wait states in the first and second cycle
  task automatic run_seq(input logic [7:0] tv, input int a, input int b,
                         input bit chain_in, input bit chain_out,
                         input bit poke, input string tag);
    int e_pulse = 0;
    int e_gap = 0;
    int e_lock = 0;
    int e_oe = 0;
    int e_rdy = 0;
    int vcount = 0;
    int vpos = -1;
    int last = 10 + a + b;
    logic [7:0] got = '0;
    logic [9:0] gotp = '0;
    if (!chain_in) begin
      @(negedge clk);
      req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
    for (int s = 1; s <= last; s++) begin
      bit lo;
      bit lk;
      bus_rdy   = !((s >= 3 && s <= 2 + a) || (s >= 8 + a && s <= 7 + a + b));
      bus_din   = (s == 9 + a + b) ? tv : ~tv;
      req_valid = (poke && s == 5 + a) || (chain_out && s == last);
      @(negedge clk);
      lo = (s >= 2 && s <= 4 + a) || (s >= 7 + a && s <= 9 + a + b);
      lk = (s < last);
      if (inta_n !== !lo) begin
        if (s == 5 + a || s == 6 + a) e_gap++;
        else e_pulse++;
      end
      if (hold_lock !== lk) e_lock++;
      if (bus_oe !== !lk) e_oe++;
      if (req_ready !== !lk) e_rdy++;
      if (type_valid) begin
        vcount++;
        vpos = s;
        got  = type_data;
        gotp = vec_ptr;
      end
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    bus_rdy   = 1'b1;
    if (a + b > 0) chk(e_pulse == 0, {"R4 command span with waits ", tag}, e_pulse, 0);
    else           chk(e_pulse == 0, {"R3 command pulses ", tag}, e_pulse, 0);
    chk(e_gap == 0, {"R5 idle gap ", tag}, e_gap, 0);
    chk(e_oe == 0, {"R6 bus float ", tag}, e_oe, 0);
    chk(e_lock == 0, {"R7 hold lock ", tag}, e_lock, 0);
    chk(e_rdy == 0, {"R2 req_ready ", tag}, e_rdy, 0);
    chk(vcount == 1 && vpos == last, {"R9 strobe position ", tag}, vpos, last);
    chk(got == tv, {"R8 captured type ", tag}, int'(got), int'(tv));
    chk(gotp == {tv, 2'b00}, {"R10 vector offset ", tag}, int'(gotp), int'(tv) * 4);
    if (!chain_out) begin
      int e_idle = 0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (!(inta_n && !hold_lock && req_ready && !type_valid && bus_oe)) e_idle++;
      end
      chk(e_idle == 0, {"R2 idle after sequence ", tag}, e_idle, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(inta_n && !hold_lock && bus_oe && !type_valid && req_ready,
        "R1 outputs during reset", {inta_n, hold_lock, bus_oe, type_valid, req_ready}, 5'b10101);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(inta_n && !hold_lock && bus_oe && !type_valid && req_ready,
        "R1 outputs after reset", {inta_n, hold_lock, bus_oe, type_valid, req_ready}, 5'b10101);
  endtask

  task automatic t_plain();
    run_seq(8'hA5, 0, 0, 1'b0, 1'b0, 1'b0, "plain");
  endtask

  task automatic t_waits();
    run_seq(8'h3C, 2, 3, 1'b0, 1'b0, 1'b0, "waits");
  endtask

  task automatic t_edges();
    run_seq(8'hFF, 0, 1, 1'b0, 1'b0, 1'b0, "all-ones");
    run_seq(8'h00, 1, 0, 1'b0, 1'b0, 1'b0, "zero");
  endtask

  task automatic t_busy_poke();
    run_seq(8'h81, 1, 0, 1'b0, 1'b0, 1'b1, "R2 request while busy");
  endtask

  task automatic t_back_to_back();
    run_seq(8'h12, 0, 0, 1'b0, 1'b1, 1'b0, "R11 first of pair");
    run_seq(8'hE7, 0, 1, 1'b1, 1'b0, 1'b0, "R11 chained");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 50000);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_plain();
    t_waits();
    t_edges();
    t_busy_poke();
    t_back_to_back();
    finish_run();
  end

endmodule